// File: doc/BRIEF.md
# Exception Prioritisation and Entry Unit

This unit runs next to a small in-order processor pipeline and decides, at every instruction boundary, whether an exception must be taken. At each boundary it looks at seven possible causes: a reset, a data abort from the memory access of the completing instruction, an active-low fast interrupt line, an active-low normal interrupt line, a prefetch-abort marker that travels with the instruction, a trap-instruction decode and an undefined-instruction decode. It picks one winner and produces the complete entry update for the pipeline to apply. The update holds the new status word (mode field forced, interrupt masks set, Thumb bit cleared), the copy of the old status word for the saved-status register, the link value and the vector address for the next fetch.

The prefetch-abort marker is tracked through a short tag pipeline. The exception is only raised when the marked instruction reaches execute, and the marker is discarded when a taken branch or an exception entry flushes that instruction. A separate return path takes a link value, a saved status word and the kind of exception being left, and produces the resume address and the restored status word. Both paths are registered: results appear one clock after the request, as single-cycle pulses.

Status word layout used throughout: bits [4:0] mode, bit 5 Thumb state, bit 6 fast-interrupt disable, bit 7 normal-interrupt disable. Exception kind encoding on `kind_o` and `ret_kind_i`: 0 reset, 1 undefined, 2 trap instruction, 3 prefetch abort, 4 data abort, 5 normal interrupt, 6 fast interrupt.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst_n` is low, and until the first rising edge after it goes high, `take_o` is 1, `kind_o` is 0, `status_o` is 0x000000D3 (mode 10011, bits 7 and 6 set, bit 5 clear) and `vector_o` is 0.
- R2: When several causes are present at a boundary (`step_i` high), the winner follows this order from highest: data abort, fast interrupt, normal interrupt, prefetch abort, then trap instruction and undefined instruction sharing the lowest level. The last two are never raised together.
- R3: On every entry `status_o` equals the current status word with bit 7 set and bit 5 cleared. Bit 6 is also set on a fast-interrupt entry and is otherwise copied. Bits above 7 are copied.
- R4: On every non-reset entry `saved_o` equals the status word present at the boundary. `link_o` is PC+8 for data abort, fast and normal interrupt, and PC+4 for prefetch abort, trap and undefined.
- R5: The mode field of `status_o` is 10001 for fast interrupt, 10010 for normal interrupt, 10011 for trap, 10111 for both aborts and 11011 for undefined.
- R6: `vector_o` is 0x04 undefined, 0x08 trap, 0x0C prefetch abort, 0x10 data abort, 0x18 normal interrupt and 0x1C fast interrupt.
- R7: A low fast-interrupt line is ignored while status bit 6 is set, and a low normal-interrupt line is ignored while status bit 7 is set. Both lines are level-sensitive and only considered when `step_i` is high.
- R8: Each interrupt line passes two flip-flops before it is considered. A line driven low just before a rising edge that carries a boundary is not taken at that edge, but it is taken at a boundary two edges later.
- R9: `fetch_abort_i`, captured when `step_i` is high, raises a prefetch abort at the second following boundary. It is dropped if a boundary with `flush_i` high or any exception entry occurs in between.
- R10: `take_o` is a single-cycle pulse one rising edge after a boundary that has a winner. It is low after a boundary with no winner and in cycles without a boundary.
- R11: One edge after `ret_i`, `ret_done_o` pulses for one cycle. `ret_status_o` equals `ret_saved_i`, and `ret_pc_o` equals `ret_link_i` minus 4 for fast interrupt, normal interrupt and prefetch abort, minus 8 for data abort, and minus 0 for trap and undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction boundary: the executing instruction completes and the pipeline advances |
| flush_i | input | 1 | Taken branch at this boundary; younger instructions are discarded |
| fetch_abort_i | input | 1 | Instruction entering the pipeline at this boundary had a fetch fault |
| data_abort_i | input | 1 | Memory access of the completing instruction faulted |
| fast_int_n_i | input | 1 | Fast interrupt request, active low, asynchronous |
| norm_int_n_i | input | 1 | Normal interrupt request, active low, asynchronous |
| swtrap_i | input | 1 | Completing instruction is a trap instruction |
| undef_i | input | 1 | Completing instruction is undefined |
| status_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Address of the completing instruction |
| ret_i | input | 1 | Exception return request |
| ret_kind_i | input | 3 | Kind of exception being left |
| ret_link_i | input | XLEN | Link value of the handler |
| ret_saved_i | input | XLEN | Saved status word to restore |
| take_o | output | 1 | Entry update valid |
| kind_o | output | 3 | Winning exception kind |
| status_o | output | XLEN | New status word |
| saved_o | output | XLEN | Value for the saved-status register |
| link_o | output | XLEN | Value for the link register |
| vector_o | output | XLEN | Next fetch address |
| ret_done_o | output | 1 | Return result valid |
| ret_pc_o | output | XLEN | Resume address |
| ret_status_o | output | XLEN | Restored status word |

## Verification
A wrong prefetch-abort tag only shows at the ports when the tagged instruction reaches execute. That is two boundaries later: a stuck tag produces an extra entry with kind 3, and a lost tag produces a missing one. The bench therefore runs both the plain and the flushed abort sequences to that second boundary. A stale synchroniser stage shows one edge later as an interrupt taken too early or too late around the R8 boundary. A wrong priority or a wrong mask bit shows on the very next `take_o` pulse, as a wrong kind, a wrong status word or a wrong vector. Every expected entry bundle is compared field by field in the cycle it is due.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int MODE_W = 5;
  localparam int BIT_T  = 5;
  localparam int BIT_F  = 6;
  localparam int BIT_I  = 7;
  localparam int VEC_W  = 5;

  typedef enum logic [2:0] {
    EK_RESET  = 3'd0,
    EK_UNDEF  = 3'd1,
    EK_SWTRAP = 3'd2,
    EK_PABT   = 3'd3,
    EK_DABT   = 3'd4,
    EK_NORM   = 3'd5,
    EK_FAST   = 3'd6
  } exc_kind_e;

  function automatic logic [MODE_W-1:0] mode_of(input exc_kind_e k);
    case (k)
      EK_FAST:           mode_of = 5'b10001;
      EK_NORM:           mode_of = 5'b10010;
      EK_PABT, EK_DABT:  mode_of = 5'b10111;
      EK_UNDEF:          mode_of = 5'b11011;
      default:           mode_of = 5'b10011;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input exc_kind_e k);
    case (k)
      EK_UNDEF:  vec_of = 5'h04;
      EK_SWTRAP: vec_of = 5'h08;
      EK_PABT:   vec_of = 5'h0C;
      EK_DABT:   vec_of = 5'h10;
      EK_NORM:   vec_of = 5'h18;
      EK_FAST:   vec_of = 5'h1C;
      default:   vec_of = 5'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_n_i,
  output logic [WIDTH-1:0] line_n_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b1;
        stable_q <= 1'b1;
      end else begin
        meta_q   <= line_n_i[g];
        stable_q <= meta_q;
      end
    end

    assign line_n_o[g] = stable_q;

    // R8: a falling output must come from a low input two edges earlier
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stable_q) |-> ($past(line_n_i[g], 2) == 1'b0));
  end

endmodule

// File: rtl/exc_pf_track.sv
module exc_pf_track #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic flush_i,
  input  logic fetch_abort_i,
  input  logic entry_i,
  output logic abort_exec_o
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] tags_q;
  logic [DEPTH-1:0] tags_d;
  logic [DEPTH-1:0] tags_shift;
  logic             clear;

  if (DEPTH == 1) begin : g_single
    assign tags_shift = fetch_abort_i;
  end else begin : g_chain
    assign tags_shift = {tags_q[DEPTH-2:0], fetch_abort_i};
  end

  assign clear = (step_i & flush_i) | entry_i;

  always_comb begin
    tags_d = tags_q;
    if (clear) begin
      tags_d = '0;
    end else if (step_i) begin
      tags_d = tags_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags_q <= '0;
    end else begin
      tags_q <= tags_d;
    end
  end

  assign abort_exec_o = tags_q[LAST];

  // R9: a flushing boundary leaves no abort marker in execute
  p_flush_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && flush_i) |=> !abort_exec_o);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            step_i,
  input  logic            dabt_i,
  input  logic            fast_n_i,
  input  logic            norm_n_i,
  input  logic            pabt_i,
  input  logic            swtrap_i,
  input  logic            undef_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            take_o,
  output exc_kind_e       kind_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] vector_o
);

  localparam logic [XLEN-1:0] OFF_NEAR = XLEN'(4);
  localparam logic [XLEN-1:0] OFF_FAR  = XLEN'(8);

  logic fast_pend;
  logic norm_pend;
  logic far_link;

  always_comb begin
    fast_pend = step_i & ~fast_n_i & ~status_i[BIT_F];
    norm_pend = step_i & ~norm_n_i & ~status_i[BIT_I];
    take_o    = 1'b1;
    kind_o    = EK_UNDEF;
    if (step_i && dabt_i) begin
      kind_o = EK_DABT;
    end else if (fast_pend) begin
      kind_o = EK_FAST;
    end else if (norm_pend) begin
      kind_o = EK_NORM;
    end else if (step_i && pabt_i) begin
      kind_o = EK_PABT;
    end else if (step_i && swtrap_i) begin
      kind_o = EK_SWTRAP;
    end else if (step_i && undef_i) begin
      kind_o = EK_UNDEF;
    end else begin
      take_o = 1'b0;
    end
  end

  always_comb begin
    status_o               = status_i;
    status_o[MODE_W-1:0]   = mode_of(kind_o);
    status_o[BIT_T]        = 1'b0;
    status_o[BIT_I]        = 1'b1;
    if (kind_o == EK_FAST) begin
      status_o[BIT_F] = 1'b1;
    end
    far_link = (kind_o == EK_DABT) || (kind_o == EK_FAST) || (kind_o == EK_NORM);
    link_o   = pc_i + (far_link ? OFF_FAR : OFF_NEAR);
    vector_o = {{(XLEN-VEC_W){1'b0}}, vec_of(kind_o)};
  end

endmodule

// File: rtl/exc_return.sv
module exc_return
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind_i,
  input  logic [XLEN-1:0] link_i,
  output logic [XLEN-1:0] resume_o
);

  logic [XLEN-1:0] back;

  always_comb begin
    case (exc_kind_e'(kind_i))
      EK_FAST, EK_NORM, EK_PABT: back = XLEN'(4);
      EK_DABT:                   back = XLEN'(8);
      default:                   back = '0;
    endcase
    resume_o = link_i - back;
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PF_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic            flush_i,
  input  logic            fetch_abort_i,
  input  logic            data_abort_i,
  input  logic            fast_int_n_i,
  input  logic            norm_int_n_i,
  input  logic            swtrap_i,
  input  logic            undef_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ret_i,
  input  logic [2:0]      ret_kind_i,
  input  logic [XLEN-1:0] ret_link_i,
  input  logic [XLEN-1:0] ret_saved_i,
  output logic            take_o,
  output logic [2:0]      kind_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] saved_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] vector_o,
  output logic            ret_done_o,
  output logic [XLEN-1:0] ret_pc_o,
  output logic [XLEN-1:0] ret_status_o
);

  localparam logic [XLEN-1:0] RESET_STATUS =
    {{(XLEN-8){1'b0}}, 1'b1, 1'b1, 1'b0, 5'b10011};

  logic [1:0]      lines_n_s;
  logic            pabt_exec;
  logic            arb_take;
  exc_kind_e       arb_kind;
  logic [XLEN-1:0] arb_status;
  logic [XLEN-1:0] arb_link;
  logic [XLEN-1:0] arb_vector;
  logic [XLEN-1:0] resume;

  exc_sync #(.WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_n_i ({fast_int_n_i, norm_int_n_i}),
    .line_n_o (lines_n_s)
  );

  exc_pf_track #(.DEPTH(PF_DEPTH)) u_pf (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_i),
    .flush_i       (flush_i),
    .fetch_abort_i (fetch_abort_i),
    .entry_i       (arb_take),
    .abort_exec_o  (pabt_exec)
  );

  exc_arbiter #(.XLEN(XLEN)) u_arb (
    .step_i   (step_i),
    .dabt_i   (data_abort_i),
    .fast_n_i (lines_n_s[1]),
    .norm_n_i (lines_n_s[0]),
    .pabt_i   (pabt_exec),
    .swtrap_i (swtrap_i),
    .undef_i  (undef_i),
    .status_i (status_i),
    .pc_i     (pc_i),
    .take_o   (arb_take),
    .kind_o   (arb_kind),
    .status_o (arb_status),
    .link_o   (arb_link),
    .vector_o (arb_vector)
  );

  exc_return #(.XLEN(XLEN)) u_ret (
    .kind_i   (ret_kind_i),
    .link_i   (ret_link_i),
    .resume_o (resume)
  );

  // next-state
  logic            take_d,   take_q;
  exc_kind_e       kind_d,   kind_q;
  logic [XLEN-1:0] status_d, status_q;
  logic [XLEN-1:0] saved_d,  saved_q;
  logic [XLEN-1:0] link_d,   link_q;
  logic [XLEN-1:0] vector_d, vector_q;
  logic            rdone_d,  rdone_q;
  logic [XLEN-1:0] rpc_d,    rpc_q;
  logic [XLEN-1:0] rstat_d,  rstat_q;

  always_comb begin
    take_d   = arb_take;
    kind_d   = kind_q;
    status_d = status_q;
    saved_d  = saved_q;
    link_d   = link_q;
    vector_d = vector_q;
    if (arb_take) begin
      kind_d   = arb_kind;
      status_d = arb_status;
      saved_d  = status_i;
      link_d   = arb_link;
      vector_d = arb_vector;
    end
    rdone_d = ret_i;
    rpc_d   = rpc_q;
    rstat_d = rstat_q;
    if (ret_i) begin
      rpc_d   = resume;
      rstat_d = ret_saved_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q   <= 1'b1;
      kind_q   <= EK_RESET;
      status_q <= RESET_STATUS;
      saved_q  <= '0;
      link_q   <= '0;
      vector_q <= '0;
      rdone_q  <= 1'b0;
      rpc_q    <= '0;
      rstat_q  <= '0;
    end else begin
      take_q   <= take_d;
      kind_q   <= kind_d;
      status_q <= status_d;
      saved_q  <= saved_d;
      link_q   <= link_d;
      vector_q <= vector_d;
      rdone_q  <= rdone_d;
      rpc_q    <= rpc_d;
      rstat_q  <= rstat_d;
    end
  end

  assign take_o       = take_q;
  assign kind_o       = kind_q;
  assign status_o     = status_q;
  assign saved_o      = saved_q;
  assign link_o       = link_q;
  assign vector_o     = vector_q;
  assign ret_done_o   = rdone_q;
  assign ret_pc_o     = rpc_q;
  assign ret_status_o = rstat_q;

  // R2: trap and undefined never arrive together
  p_low_level_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !(swtrap_i && undef_i));

  // R3: every entry masks normal interrupts and leaves Thumb state
  p_entry_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (status_o[BIT_I] && !status_o[BIT_T]));

  // R3: fast entry also masks fast interrupts
  p_fast_masks_f_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == EK_FAST) |-> status_o[BIT_F]);

  // R4: saved copy is the status word seen at the boundary
  p_saved_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o != EK_RESET) |-> (saved_o == $past(status_i)));

  // R10: a non-reset entry pulse follows a boundary
  p_entry_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o != EK_RESET) |-> $past(step_i));

  // R11: return result restores the saved word of the request
  p_ret_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done_o |-> ($past(ret_i) && ret_status_o == $past(ret_saved_i)));

endmodule

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, flush_i, fetch_abort_i, data_abort_i;
  logic        fast_int_n_i, norm_int_n_i, swtrap_i, undef_i;
  logic [31:0] status_i, pc_i;
  logic        ret_i;
  logic [2:0]  ret_kind_i;
  logic [31:0] ret_link_i, ret_saved_i;
  logic        take_o;
  logic [2:0]  kind_o;
  logic [31:0] status_o, saved_o, link_o, vector_o;
  logic        ret_done_o;
  logic [31:0] ret_pc_o, ret_status_o;

  always #4 clk = ~clk;

  exc_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .flush_i(flush_i),
    .fetch_abort_i(fetch_abort_i), .data_abort_i(data_abort_i),
    .fast_int_n_i(fast_int_n_i), .norm_int_n_i(norm_int_n_i),
    .swtrap_i(swtrap_i), .undef_i(undef_i), .status_i(status_i), .pc_i(pc_i),
    .ret_i(ret_i), .ret_kind_i(ret_kind_i), .ret_link_i(ret_link_i),
    .ret_saved_i(ret_saved_i), .take_o(take_o), .kind_o(kind_o),
    .status_o(status_o), .saved_o(saved_o), .link_o(link_o),
    .vector_o(vector_o), .ret_done_o(ret_done_o), .ret_pc_o(ret_pc_o),
    .ret_status_o(ret_status_o)
  );

  typedef struct {
    int          due;
    bit          take;
    logic [2:0]  kind;
    logic [31:0] st, sv, lr, vec;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nbad = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // kinds: 1 undef, 2 trap, 3 prefetch abort, 4 data abort, 5 normal, 6 fast
  function automatic logic [4:0] m_mode(int k);
    case (k)
      6: return 5'b10001;
      5: return 5'b10010;
      3, 4: return 5'b10111;
      1: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] m_vec(int k);
    case (k)
      1: return 32'h04;
      2: return 32'h08;
      3: return 32'h0C;
      4: return 32'h10;
      5: return 32'h18;
      6: return 32'h1C;
      default: return 32'h00;
    endcase
  endfunction

  function automatic logic [31:0] m_status(int k, logic [31:0] s);
    logic [31:0] r;
    r = s;
    r[4:0] = m_mode(k);
    r[7] = 1'b1;
    r[5] = 1'b0;
    if (k == 6) r[6] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_link(int k, logic [31:0] pc);
    return (k == 4 || k == 5 || k == 6) ? pc + 32'd8 : pc + 32'd4;
  endfunction

  task automatic push_exp(bit tk, int k, logic [31:0] st, logic [31:0] pc, string req);
    exp_t e;
    e.due  = cyc + 1;
    e.take = tk;
    e.kind = 3'(k);
    e.st   = m_status(k, st);
    e.sv   = st;
    e.lr   = m_link(k, pc);
    e.vec  = m_vec(k);
    e.req  = req;
    q.push_back(e);
  endtask

  task automatic do_step(bit dabt, bit sw, bit un, bit fab, bit fl,
                         logic [31:0] st, logic [31:0] pc,
                         bit tk, int k, string req);
    @(negedge clk);
    step_i = 1'b1; data_abort_i = dabt; swtrap_i = sw; undef_i = un;
    fetch_abort_i = fab; flush_i = fl; status_i = st; pc_i = pc;
    push_exp(tk, k, st, pc, req);
    @(negedge clk);
    step_i = 1'b0; data_abort_i = 1'b0; swtrap_i = 1'b0; undef_i = 1'b0;
    fetch_abort_i = 1'b0; flush_i = 1'b0;
    push_exp(1'b0, 0, st, pc, "R10 pulse");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string msg);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      #1;
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (!e.take) begin
          chk(take_o == 1'b0, e.req,
              $sformatf("take actual=%0b expected=0", take_o));
        end else begin
          chk(take_o && kind_o == e.kind && status_o == e.st && saved_o == e.sv &&
              link_o == e.lr && vector_o == e.vec, e.req,
              $sformatf("actual take=%0b kind=%0d st=%h sv=%h lr=%h vec=%h expected take=1 kind=%0d st=%h sv=%h lr=%h vec=%h",
                        take_o, kind_o, status_o, saved_o, link_o, vector_o,
                        e.kind, e.st, e.sv, e.lr, e.vec));
        end
      end else if (take_o) begin
        chk(1'b0, "R10", $sformatf("unexpected take actual=1 kind=%0d expected=0", kind_o));
      end
    end
  end

  task automatic do_ret(int k, logic [31:0] lr, logic [31:0] sv, logic [31:0] exp_pc);
    @(negedge clk);
    ret_i = 1'b1; ret_kind_i = 3'(k); ret_link_i = lr; ret_saved_i = sv;
    @(negedge clk);
    ret_i = 1'b0;
    #1;
    chk(ret_done_o && ret_pc_o == exp_pc && ret_status_o == sv, "R11",
        $sformatf("actual done=%0b pc=%h st=%h expected done=1 pc=%h st=%h",
                  ret_done_o, ret_pc_o, ret_status_o, exp_pc, sv));
    @(negedge clk);
    #1;
    chk(ret_done_o == 1'b0, "R11",
        $sformatf("pulse actual=%0b expected=0", ret_done_o));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", "actual=running expected=finished");
    finish_run();
  end

  localparam logic [31:0] U = 32'h0000_0010;

  initial begin
    rst_n = 1'b0;
    step_i = 0; flush_i = 0; fetch_abort_i = 0; data_abort_i = 0;
    fast_int_n_i = 1; norm_int_n_i = 1; swtrap_i = 0; undef_i = 0;
    status_i = U; pc_i = 0; ret_i = 0; ret_kind_i = 0; ret_link_i = 0; ret_saved_i = 0;
    idle(3);
    #1;
    // R1 reset entry
    chk(take_o == 1'b1, "R1", $sformatf("take actual=%0b expected=1", take_o));
    chk(kind_o == 3'd0, "R1", $sformatf("kind actual=%0d expected=0", kind_o));
    chk(status_o == 32'hD3, "R1", $sformatf("status actual=%h expected=000000d3", status_o));
    chk(vector_o == 32'h0, "R1", $sformatf("vector actual=%h expected=0", vector_o));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    mon_on = 1'b1;

    do_step(0,0,0,0,0, U, 32'h080, 0, 0, "R2 no cause");
    do_step(0,1,0,0,0, U, 32'h100, 1, 2, "R5 R6 trap");
    do_step(0,0,1,0,0, U, 32'h200, 1, 1, "R5 R6 undef");
    do_step(1,1,0,0,0, U, 32'h300, 1, 4, "R2 R4 dabt over trap");
    do_step(0,1,0,0,0, 32'hF000_0030, 32'h400, 1, 2, "R3 keep high bits clear T");

    // R8 synchroniser latency
    norm_int_n_i = 1'b0;
    do_step(0,0,0,0,0, U, 32'h480, 0, 0, "R8 not yet");
    do_step(0,0,0,0,0, U, 32'h500, 1, 5, "R8 R4 normal");
    do_step(0,0,0,0,0, 32'h90, 32'h540, 0, 0, "R7 normal masked");
    fast_int_n_i = 1'b0;
    idle(3);
    do_step(0,0,0,0,0, 32'h90, 32'h600, 1, 6, "R5 R6 fast");
    do_step(0,0,0,0,0, U, 32'h640, 1, 6, "R2 fast over normal");
    do_step(0,0,0,0,0, 32'h50, 32'h680, 1, 5, "R7 fast masked");
    do_step(0,0,0,0,0, 32'hD0, 32'h6C0, 0, 0, "R7 both masked");
    do_step(1,0,0,0,0, U, 32'h700, 1, 4, "R2 dabt over fast");
    fast_int_n_i = 1'b1;
    norm_int_n_i = 1'b1;
    idle(3);

    // R9 prefetch abort tracking
    do_step(0,0,0,1,0, U, 32'h800, 0, 0, "R9 tag in");
    do_step(0,0,0,0,0, U, 32'h804, 0, 0, "R9 tag moving");
    do_step(0,0,0,0,0, U, 32'h808, 1, 3, "R9 R5 R6 pabt");
    do_step(0,0,0,1,0, U, 32'h900, 0, 0, "R9 tag in");
    do_step(0,0,0,0,1, U, 32'h904, 0, 0, "R9 flush");
    do_step(0,0,0,0,0, U, 32'hA00, 0, 0, "R9 flushed");
    do_step(0,0,0,0,0, U, 32'hA04, 0, 0, "R9 flushed");
    do_step(0,0,0,1,0, U, 32'hB00, 0, 0, "R9 tag in");
    do_step(1,0,0,0,0, U, 32'hB04, 1, 4, "R9 entry clears");
    do_step(0,0,0,0,0, U, 32'h010, 0, 0, "R9 cleared");
    do_step(0,0,0,1,0, U, 32'hC00, 0, 0, "R9 tag in");
    do_step(0,0,0,0,0, U, 32'hC04, 0, 0, "R9 tag moving");
    do_step(0,1,0,0,0, U, 32'hC08, 1, 3, "R2 pabt over trap");

    // R11 return path
    do_ret(6, 32'h208, 32'h1F, 32'h204);
    do_ret(5, 32'h208, 32'h10, 32'h204);
    do_ret(3, 32'h208, 32'h30, 32'h204);
    do_ret(4, 32'h208, 32'h10, 32'h200);
    do_ret(2, 32'h208, 32'h10, 32'h208);
    do_ret(1, 32'h208, 32'h10, 32'h208);

    idle(3);
    chk(q.size() == 0, "R10", $sformatf("pending actual=%0d expected=0", q.size()));
    finish_run();
  end

endmodule